// File: doc/BRIEF.md
# Parallel Display Bus Write Master

This block sends command and pixel words to a display controller over a parallel write-only bus. The host starts a transfer by giving an optional 8-bit command, a word count and a bus mode. The block then takes the data words one at a time through a valid/ready handshake and clocks each one onto the pins with a strobe pulse.

Two bus styles can be chosen at run time. In write-strobe style, the write line pulses low for each word and the word is latched on its rising edge. In enable-strobe style, the read/write line stays low for the whole transfer and the enable line pulses high for each word. The word is latched on its falling edge. The command and all data words share one chip-select window. The data/command line is low for the command and high for data. A separate request produces a timed active-low reset pulse for the panel. The length of each strobe phase is set in clock cycles.

Top module: `dbi_wr_master`

## Requirements
- R1: With mode 2'b01 (write-strobe style), every word is presented with wr_o falling and latched when wr_o rises. en_o stays low throughout.
- R2: When has_cmd_i is set, the first word on the bus is cmd_i with dc_o low. It is followed by exactly count_i data words with dc_o high, in the order accepted. Bus bit i carries word bit i.
- R3: With mode 2'b10 (enable-strobe style), wr_o is held low while chip select is active. Each word is latched by en_o rising and then falling.
- R4: cs_n_o falls once at the start of a transfer and rises once, after the last word's recovery phase. done_o is a one-cycle pulse in the cycle in which cs_n_o rises.
- R5: Without a command, the first strobed word already has dc_o high. With no command and a count of zero, the block opens and closes chip select without any strobe and pulses done_o.
- R6: Out of reset and while idle: cs_n_o=1, dc_o=0, wr_o=1, rd_o=1, en_o=0, lcd_rst_n_o=1, bus_o=0, busy_o=0, wd_ready_o=0.
- R7: A start with mode 2'b00 or 2'b11 pulses err_o for one cycle and causes no pin activity.
- R8: A reset request drives lcd_rst_n_o low for rst_len_i cycles, with 0 treated as 1, and then releases it.
- R9: The strobe's active phase lasts t_act_i cycles and its recovery phase lasts t_rec_i cycles, with 0 treated as 1 in both. bus_o and dc_o do not change while the strobe is active.
- R10: wd_ready_o is high only between words, never while a strobe is active. A word is taken in a cycle where wd_valid_i and wd_ready_o are both high.
- R11: busy_o is high from an accepted request until the block is idle again. start_i and rst_req_i are ignored while busy. If both arrive together while idle, the reset request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bus style: 01 write-strobe, 10 enable-strobe |
| t_act_i | input | TW | Strobe active phase length in cycles |
| t_rec_i | input | TW | Strobe recovery phase length in cycles |
| rst_len_i | input | RW | Panel reset pulse length in cycles |
| start_i | input | 1 | Start a transfer |
| has_cmd_i | input | 1 | Transfer begins with a command word |
| cmd_i | input | 8 | Command word |
| count_i | input | CW | Number of data words |
| wd_valid_i | input | 1 | Data word valid |
| wd_i | input | DW | Data word |
| wd_ready_o | output | 1 | Block can take a data word |
| rst_req_i | input | 1 | Request a panel reset pulse |
| busy_o | output | 1 | Transfer or reset in progress |
| done_o | output | 1 | Transfer finished (one cycle) |
| err_o | output | 1 | Start rejected for a bad mode (one cycle) |
| cs_n_o | output | 1 | Chip select, active low |
| dc_o | output | 1 | Data (1) or command (0) |
| wr_o | output | 1 | Write strobe, or read/write level in enable-strobe style |
| rd_o | output | 1 | Read strobe, held inactive high |
| en_o | output | 1 | Enable strobe |
| lcd_rst_n_o | output | 1 | Panel reset, active low |
| bus_o | output | DW | Data lines |

## Verification
The bench targets phase lengths of zero, which must act as one cycle; a design that used zero literally would wrap its counter and hold the strobe for hundreds of cycles. It covers command-only transfers and transfers with no command and no data; a wrong design there would either strobe a phantom word or never close chip select. It stalls the data stream so that ready and valid meet out of phase; a design that raised ready during a strobe would change the bus mid-pulse or lose words. It also sends requests while the block is busy, which must not cut a reset pulse short or start a second chip-select window.

// File: rtl/dbi_wr_master.sv
`timescale 1ns/1ps
module dbi_wr_master #(
  parameter int DW = 8,
  parameter int CW = 16,
  parameter int TW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic [TW-1:0] t_act_i,
  input  logic [TW-1:0] t_rec_i,
  input  logic [RW-1:0] rst_len_i,
  input  logic          start_i,
  input  logic          has_cmd_i,
  input  logic [7:0]    cmd_i,
  input  logic [CW-1:0] count_i,
  input  logic          wd_valid_i,
  input  logic [DW-1:0] wd_i,
  output logic          wd_ready_o,
  input  logic          rst_req_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          cs_n_o,
  output logic          dc_o,
  output logic          wr_o,
  output logic          rd_o,
  output logic          en_o,
  output logic          lcd_rst_n_o,
  output logic [DW-1:0] bus_o
);
  localparam int KW = (TW > RW) ? TW : RW;
  localparam logic [1:0] MODE_WR = 2'b01;
  localparam logic [1:0] MODE_EN = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_REC, S_WAIT, S_FIN, S_RST} state_t;

  state_t        state;
  logic [KW-1:0] cnt;
  logic [CW-1:0] left;
  logic [TW-1:0] act_m1, rec_m1;
  logic          en_style;

  wire [TW-1:0] act_in = (t_act_i == '0) ? '0 : t_act_i - 1'b1;
  wire [TW-1:0] rec_in = (t_rec_i == '0) ? '0 : t_rec_i - 1'b1;
  wire          mode_ok = (mode_i == MODE_WR) || (mode_i == MODE_EN);

  assign wd_ready_o = (state == S_WAIT);
  assign busy_o     = (state != S_IDLE);
  assign rd_o       = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      left        <= '0;
      act_m1      <= '0;
      rec_m1      <= '0;
      en_style    <= 1'b0;
      cs_n_o      <= 1'b1;
      dc_o        <= 1'b0;
      wr_o        <= 1'b1;
      en_o        <= 1'b0;
      lcd_rst_n_o <= 1'b1;
      bus_o       <= '0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (rst_req_i) begin
            lcd_rst_n_o <= 1'b0;
            cnt         <= KW'((rst_len_i == '0) ? '0 : rst_len_i - 1'b1);
            state       <= S_RST;
          end else if (start_i && !mode_ok) begin
            err_o <= 1'b1;
          end else if (start_i) begin
            en_style <= (mode_i == MODE_EN);
            act_m1   <= act_in;
            rec_m1   <= rec_in;
            left     <= count_i;
            cs_n_o   <= 1'b0;
            wr_o     <= (mode_i == MODE_EN) ? 1'b0 : !has_cmd_i;
            en_o     <= (mode_i == MODE_EN) && has_cmd_i;
            if (has_cmd_i) begin
              dc_o  <= 1'b0;
              bus_o <= DW'(cmd_i);
              cnt   <= KW'(act_in);
              state <= S_ACT;
            end else if (count_i == '0) begin
              state <= S_FIN;
            end else begin
              dc_o  <= 1'b1;
              state <= S_WAIT;
            end
          end
        end
        S_ACT: begin
          if (cnt == '0) begin
            if (en_style) en_o <= 1'b0;
            else          wr_o <= 1'b1;
            cnt   <= KW'(rec_m1);
            state <= S_REC;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_REC: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (left != '0) begin
            state <= S_WAIT;
          end else begin
            cs_n_o <= 1'b1;
            done_o <= 1'b1;
            dc_o   <= 1'b0;
            wr_o   <= 1'b1;
            bus_o  <= '0;
            state  <= S_IDLE;
          end
        end
        S_WAIT: begin
          if (wd_valid_i) begin
            bus_o <= wd_i;
            dc_o  <= 1'b1;
            if (en_style) en_o <= 1'b1;
            else          wr_o <= 1'b0;
            left  <= left - 1'b1;
            cnt   <= KW'(act_m1);
            state <= S_ACT;
          end
        end
        S_FIN: begin
          cs_n_o <= 1'b1;
          done_o <= 1'b1;
          dc_o   <= 1'b0;
          wr_o   <= 1'b1;
          bus_o  <= '0;
          state  <= S_IDLE;
        end
        S_RST: begin
          if (cnt == '0) begin
            lcd_rst_n_o <= 1'b1;
            state       <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module dbi_wr_master_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic          wd_ready_o,
  input logic          cs_n_o,
  input logic          dc_o,
  input logic          wr_o,
  input logic          en_o,
  input logic          lcd_rst_n_o,
  input logic [DW-1:0] bus_o
);
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs_n_o && wr_o && !en_o && !dc_o && lcd_rst_n_o && bus_o == '0)); // R6
  AST_DONE_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $rose(cs_n_o)); // R4
  AST_CS_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> done_o); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (cs_n_o && !busy_o)); // R7
  AST_RESET_PULSE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n_o |-> (busy_o && cs_n_o)); // R8
  AST_READY_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready_o |-> !en_o); // R10
  AST_EN_HOLD_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_o && $past(en_o)) |-> ($stable(bus_o) && $stable(dc_o))); // R9
endmodule

bind dbi_wr_master dbi_wr_master_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_dbi_wr_master.sv
`timescale 1ns/1ps
module test_dbi_wr_master;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode_i = 2'b01;
  logic [7:0] t_act_i = 8'd1, t_rec_i = 8'd1;
  logic [15:0] rst_len_i = 16'd1;
  logic start_i = 1'b0, has_cmd_i = 1'b0, wd_valid_i = 1'b0, rst_req_i = 1'b0;
  logic [7:0] cmd_i = '0;
  logic [15:0] count_i = '0;
  logic [DW-1:0] wd_i = '0;
  logic wd_ready_o, busy_o, done_o, err_o, cs_n_o, dc_o, wr_o, rd_o, en_o, lcd_rst_n_o;
  logic [DW-1:0] bus_o;

  always #2.5 clk = ~clk;

  dbi_wr_master i_dbi_wr_master (.*);

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // pin monitor
  bit mode_en_t = 1'b0;
  int exp_act = 1;
  int cap_n, act_run, width_bad, rec_run, last_rec, done_n, csrise_n, csfall_n;
  int en_bad, awr_bad, rdy_bad, err_n, rst_low_n;
  logic [8:0] cap [0:31];
  bit prev_strobe = 1'b0, prev_cs = 1'b1;

  task automatic clr();
    cap_n = 0; act_run = 0; width_bad = 0; rec_run = 0; last_rec = -1; done_n = 0;
    csrise_n = 0; csfall_n = 0; en_bad = 0; awr_bad = 0; rdy_bad = 0; err_n = 0; rst_low_n = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    bit strobe;
    strobe = mode_en_t ? en_o : !wr_o;
    if (strobe) begin
      act_run++;
      rec_run = 0;
      if (wd_ready_o) rdy_bad++;
    end
    if (!strobe && prev_strobe) begin
      if (cap_n < 32) cap[cap_n] = {dc_o, bus_o};
      cap_n++;
      if (act_run != exp_act) width_bad++;
      act_run = 0;
    end
    if (!strobe && !cs_n_o) rec_run++;
    if (cs_n_o && !prev_cs) begin csrise_n++; last_rec = rec_run; rec_run = 0; end
    if (!cs_n_o && prev_cs) csfall_n++;
    if (mode_en_t && !cs_n_o && wr_o) awr_bad++;
    if (!mode_en_t && en_o) en_bad++;
    if (done_o) done_n++;
    if (err_o) err_n++;
    if (!lcd_rst_n_o) rst_low_n++;
    prev_strobe = strobe;
    prev_cs = cs_n_o;
  end

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return 8'(int'(seed) + i * 37);
  endfunction

  task automatic settle();
    @(posedge clk); #1; clr();
  endtask

  task automatic run_xfer(input logic [1:0] md, input bit hc, input logic [7:0] cm,
                          input int cnt, input int p1, input int p2, input logic [7:0] seed,
                          input bit gap, input bit poke);
    int i, guard, cyc;
    bit took;
    settle();
    mode_en_t = (md == 2'b10);
    exp_act = (p1 == 0) ? 1 : p1;
    mode_i = md; has_cmd_i = hc; cmd_i = cm; count_i = 16'(cnt);
    t_act_i = 8'(p1); t_rec_i = 8'(p2); rst_len_i = 16'd3;
    i = 0; took = 1'b0; cyc = 0; guard = 0;
    wd_i = pat(seed, 0); wd_valid_i = 1'b1;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    while (done_n == 0 && guard < 3000) begin
      if (took) begin i++; wd_i = pat(seed, i); end
      cyc++;
      wd_valid_i = gap ? cyc[0] : 1'b1;
      rst_req_i = poke && (cyc == 3);
      took = wd_ready_o && wd_valid_i;
      @(negedge clk);
      guard++;
    end
    wd_valid_i = 1'b0; rst_req_i = 1'b0;
    repeat (4) @(negedge clk);
    chk(cap_n == int'(hc) + cnt, "R2 word count", cap_n, int'(hc) + cnt);
    for (int k = 0; k < cap_n && k < 32; k++) begin
      logic [8:0] e;
      e = (hc && k == 0) ? {1'b0, cm} : {1'b1, pat(seed, k - int'(hc))};
      chk(cap[k] == e, (md == 2'b10) ? "R3 word/dc (enable style)" : "R1 word/dc (write style)",
          cap[k], e);
    end
    if (!hc && cap_n > 0) chk(cap[0][8] == 1'b1, "R5 first word dc high", cap[0][8], 1);
    chk(width_bad == 0, "R9 active phase width", width_bad, 0);
    if (cap_n > 0) chk(last_rec == ((p2 == 0) ? 1 : p2), "R9 recovery width", last_rec, (p2 == 0) ? 1 : p2);
    chk(done_n == 1 && csrise_n == 1 && csfall_n == 1, "R4 single cs window + done",
        {done_n[7:0], csrise_n[7:0], csfall_n[7:0]}, 24'h010101);
    if (md == 2'b10) chk(awr_bad == 0, "R3 rw held low", awr_bad, 0);
    else             chk(en_bad == 0, "R1 enable stays low", en_bad, 0);
    chk(rdy_bad == 0, "R10 ready during strobe", rdy_bad, 0);
    if (poke) chk(rst_low_n == 0, "R11 reset request ignored while busy", rst_low_n, 0);
  endtask

  // mode[35:34] cmd_flag[33] gap[32] cmd[31:24] count[23:16] t_act[15:12] t_rec[11:8] seed[7:0]
  localparam logic [35:0] VEC [0:6] = '{
    {2'b01, 1'b1, 1'b0, 8'h2C, 8'd4, 4'd1, 4'd1, 8'h10},
    {2'b10, 1'b1, 1'b1, 8'h3A, 8'd3, 4'd2, 4'd3, 8'hA0},
    {2'b01, 1'b0, 1'b1, 8'h00, 8'd5, 4'd3, 4'd1, 8'hF0},
    {2'b10, 1'b0, 1'b0, 8'h00, 8'd2, 4'd1, 4'd1, 8'h55},
    {2'b01, 1'b1, 1'b0, 8'h29, 8'd0, 4'd0, 4'd2, 8'h00},
    {2'b10, 1'b1, 1'b0, 8'h11, 8'd0, 4'd4, 4'd0, 8'h00},
    {2'b01, 1'b1, 1'b1, 8'hB5, 8'd6, 4'd2, 4'd0, 8'hC3}
  };

  bit finished = 1'b0;
  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset levels
    chk(cs_n_o == 1'b1, "R6 cs idle", cs_n_o, 1);
    chk(dc_o == 1'b0 && bus_o == '0, "R6 dc/bus idle", {dc_o, bus_o}, 0);
    chk(wr_o && rd_o && !en_o, "R6 strobes idle", {wr_o, rd_o, en_o}, 3'b110);
    chk(lcd_rst_n_o && !busy_o && !wd_ready_o, "R6 reset/busy/ready idle",
        {lcd_rst_n_o, busy_o, wd_ready_o}, 3'b100);

    for (int v = 0; v < 7; v++) begin
      logic [35:0] x;
      x = VEC[v];
      run_xfer(x[35:34], x[33], x[31:24], int'(x[23:16]), int'(x[15:12]), int'(x[11:8]),
               x[7:0], x[32], 1'b0);
    end

    // R5 no command, zero count
    settle();
    mode_en_t = 1'b0; mode_i = 2'b01; has_cmd_i = 1'b0; count_i = '0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (6) @(negedge clk);
    chk(cap_n == 0, "R5 empty transfer strobes", cap_n, 0);
    chk(done_n == 1 && csrise_n == 1, "R5 empty transfer done", {done_n[7:0], csrise_n[7:0]}, 16'h0101);

    // R7 bad modes
    for (int m = 0; m < 4; m += 3) begin
      settle();
      mode_i = 2'(m); has_cmd_i = 1'b1; count_i = 16'd2;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      repeat (6) @(negedge clk);
      chk(err_n == 1, "R7 error pulse", err_n, 1);
      chk(csfall_n == 0 && !busy_o && wr_o && !en_o, "R7 no pin activity", csfall_n, 0);
    end

    // R8 reset pulse length, including zero
    for (int k = 0; k < 2; k++) begin
      settle();
      rst_len_i = (k == 0) ? 16'd5 : 16'd0;
      @(negedge clk) rst_req_i = 1'b1;
      @(negedge clk) rst_req_i = 1'b0;
      repeat (10) @(negedge clk);
      chk(rst_low_n == ((k == 0) ? 5 : 1), "R8 reset pulse width", rst_low_n, (k == 0) ? 5 : 1);
    end

    // R11 start ignored during reset pulse; reset wins over simultaneous start
    settle();
    mode_i = 2'b01; has_cmd_i = 1'b1; cmd_i = 8'h77; count_i = 16'd1; rst_len_i = 16'd6;
    @(negedge clk) rst_req_i = 1'b1; start_i = 1'b1;
    @(negedge clk) rst_req_i = 1'b0;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1, "R11 busy during reset pulse", busy_o, 1);
    repeat (10) @(negedge clk);
    chk(rst_low_n == 6, "R11 reset wins, full width", rst_low_n, 6);
    chk(csfall_n == 0, "R11 start ignored while busy", csfall_n, 0);

    // R11 reset request ignored during a transfer
    run_xfer(2'b01, 1'b1, 8'h5A, 4, 2, 2, 8'h33, 1'b0, 1'b1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule